// File: doc/BRIEF.md
# BCH Error-Location Bit Corrector

This block applies the output of an eight-error BCH decoder to one 512-byte chunk held in a byte-wide buffer. A pulse on `start` samples four 32-bit result words from the decoder. The status word carries a 4-bit error count. The three ECC words and the status word together carry up to eight 13-bit error locations, packed back to back. Several locations cross a 32-bit word boundary. When the count is between 1 and 8, the block turns each location into a bit address and inverts that bit in the buffer, one read-modify-write per clock.

When the count is above 8, the decoder result cannot be trusted. The chunk may simply be erased, and an erased chunk fails decoding because its ECC bytes read as all ones. To catch this, the block scans all 525 buffer bytes and counts their zero bits. If the total is small enough, the data area is rewritten to all ones and the chunk is reported as repaired. Otherwise the chunk is flagged as uncorrectable.

The buffer holds the 512 data bytes at addresses 0 to 511 and the 13 ECC bytes at addresses 512 to 524. Its read port is combinational, and a write lands on the clock edge.

Top module: `bfx_corrector`

## Requirements
- R1: The error count is status bits [13:10]. When `start` is sampled with a count of 0, `done` rises one cycle later with `corrected` = 0 and `uncorrectable` = 0, and no buffer write occurs.
- R2: The locations are taken from the 104-bit vector {status[23:16], ecc_w3, ecc_w2, ecc_w1}. Location k occupies bits [13k+12:13k] of that vector, so location 2 is {ecc_w2[6:0], ecc_w1[31:26]}. All other status bits are ignored.
- R3: Bits 0 and 1 of every location are inverted before the location is used.
- R4: An adjusted location L below 4096 inverts bit L[2:0] of buffer byte L>>3, with bit 0 as the least significant bit. A location of 4096 or above causes no write. No write in this mode ever addresses a byte at or above 512.
- R5: For a count n in 1..8, only locations 0..n-1 are applied, in order, one per cycle. `done` rises n+1 cycles after `start` with `corrected` = n. A location that appears twice is therefore applied twice, and the two inversions cancel.
- R6: For a count of 9..15, the block reads buffer bytes 0..524, one per cycle. It counts zero bits separately for the data bytes and the ECC bytes, and each count saturates at 9.
- R7: If the two zero counts sum to at most 8, data bytes 0..511 are written to 0xFF and the ECC bytes are left unchanged. `done` rises 1038 cycles after `start`, with `corrected` equal to the sum and `uncorrectable` = 0.
- R8: If the sum exceeds 8, the buffer is left unchanged. `done` rises 526 cycles after `start`, with `uncorrectable` = 1 and `corrected` = 0.
- R9: `start` is ignored while a chunk is in progress.
- R10: `done` is a one-cycle pulse. `corrected` and `uncorrectable` stay valid from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing one chunk |
| ecc_w1 | input | 32 | Decoder result word 1, locations 0 to 2 (low part) |
| ecc_w2 | input | 32 | Decoder result word 2 |
| ecc_w3 | input | 32 | Decoder result word 3 |
| status | input | 32 | Error count in [13:10], top 8 location bits in [23:16] |
| buf_addr | output | 10 | Buffer byte address |
| buf_rdata | input | 8 | Buffer read data for `buf_addr`, combinational |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | One-cycle completion pulse |
| corrected | output | 4 | Number of corrected bits |
| uncorrectable | output | 1 | Chunk could not be repaired |

## Verification
The bench aims at three groups of corner cases.

The first is the packing of the three locations that straddle word boundaries, together with the exact limits 4095 and 4096. A wrong slice or a missing bit-pair inversion flips the wrong bit. A wrong limit either writes into the ECC bytes or drops the last data bit.

The second group covers the count rules: a count of 0 with garbage locations present, a partial count with nonzero locations left unused, and a duplicated location. A design that ignores the count disturbs bytes it should leave alone. A design that deduplicates locations leaves a bit flipped that should have cancelled.

The third group is the erased-page path. It checks a total of exactly 8, a total of 9, and a chunk that is already clean. Errors there show up as wrong completion latency, as ECC bytes being overwritten, or as a failure being reported for a page that is recoverable.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIX,
        ST_SCAN,
        ST_FILL,
        ST_DONE
    } bfx_state_e;

endpackage

// File: rtl/bfx_loc_unpack.sv
module bfx_loc_unpack #(
    parameter int MAX_FIX = 8,
    parameter int LOC_W   = 13,
    localparam int PK_W   = MAX_FIX * LOC_W,
    localparam int TOP_W  = PK_W - 96
) (
    input  logic [31:0]                    w1,
    input  logic [31:0]                    w2,
    input  logic [31:0]                    w3,
    input  logic [TOP_W-1:0]               top_bits,
    output logic [MAX_FIX-1:0][LOC_W-1:0]  locs
);
    logic [PK_W-1:0] packed_v;

    assign packed_v = {top_bits, w3, w2, w1};

    for (genvar k = 0; k < MAX_FIX; k++) begin : g_loc
        // low two bits come out of the decoder inverted
        assign locs[k] = packed_v[k*LOC_W +: LOC_W] ^ LOC_W'(3);
    end
endmodule

// File: rtl/bfx_zero_pop.sv
module bfx_zero_pop (
    input  logic [7:0] byte_in,
    output logic [3:0] zeros
);
    always_comb begin
        zeros = '0;
        for (int i = 0; i < 8; i++) begin
            zeros = zeros + {3'b000, ~byte_in[i]};
        end
    end
endmodule

// File: rtl/bfx_corrector.sv
module bfx_corrector
    import bfx_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int ECC_BYTES  = 13,
    parameter int MAX_FIX    = 8,
    parameter int LOC_W      = 13,
    parameter int CNT_LSB    = 10,
    parameter int CNT_W      = 4,
    localparam int TOT_BYTES = DATA_BYTES + ECC_BYTES,
    localparam int AW        = $clog2(TOT_BYTES),
    localparam int PK_W      = MAX_FIX * LOC_W,
    localparam int TOP_W     = PK_W - 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      ecc_w1,
    input  logic [31:0]      ecc_w2,
    input  logic [31:0]      ecc_w3,
    input  logic [31:0]      status,
    output logic [AW-1:0]    buf_addr,
    input  logic [7:0]       buf_rdata,
    output logic             buf_we,
    output logic [7:0]       buf_wdata,
    output logic             done,
    output logic [CNT_W-1:0] corrected,
    output logic             uncorrectable
);
    localparam int DATA_BITS = DATA_BYTES * 8;
    localparam int IDXW      = $clog2(MAX_FIX);
    localparam int SAT       = MAX_FIX + 1;
    localparam int ZW        = $clog2(SAT + 1);

    typedef struct packed {
        bfx_state_e                   st;
        logic [AW-1:0]                idx;
        logic [CNT_W-1:0]             cnt;
        logic [MAX_FIX-1:0][LOC_W-1:0] locs;
        logic [ZW-1:0]                dz;
        logic [ZW-1:0]                ez;
        logic [CNT_W-1:0]             fixed;
        logic                         bad;
    } regs_t;

    regs_t q, d;

    logic [MAX_FIX-1:0][LOC_W-1:0] new_locs;
    logic [CNT_W-1:0]              new_cnt;
    logic [LOC_W-1:0]              cur_loc;
    logic [3:0]                    byte_zeros;
    logic [ZW:0]                   zero_total;
    logic                          unused_status;

    assign new_cnt       = status[CNT_LSB +: CNT_W];
    assign unused_status = ^{status[31:16+TOP_W], status[15:CNT_LSB+CNT_W], status[CNT_LSB-1:0]};
    assign cur_loc       = q.locs[q.idx[IDXW-1:0]];

    bfx_loc_unpack #(.MAX_FIX(MAX_FIX), .LOC_W(LOC_W)) u_unpack (
        .w1       (ecc_w1),
        .w2       (ecc_w2),
        .w3       (ecc_w3),
        .top_bits (status[16 +: TOP_W]),
        .locs     (new_locs)
    );

    bfx_zero_pop u_pop (
        .byte_in (buf_rdata),
        .zeros   (byte_zeros)
    );

    function automatic logic [ZW-1:0] sat_add(logic [ZW-1:0] a, logic [3:0] b);
        logic [ZW+3:0] s;
        s = (ZW+4)'(a) + (ZW+4)'(b);
        return (s > (ZW+4)'(SAT)) ? ZW'(SAT) : s[ZW-1:0];
    endfunction

    always_comb begin
        d          = q;
        buf_addr   = q.idx;
        buf_we     = 1'b0;
        buf_wdata  = buf_rdata;
        zero_total = '0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.cnt   = new_cnt;
                    d.locs  = new_locs;
                    d.idx   = '0;
                    d.dz    = '0;
                    d.ez    = '0;
                    d.fixed = '0;
                    d.bad   = 1'b0;
                    if (new_cnt == '0)
                        d.st = ST_DONE;
                    else if (new_cnt <= CNT_W'(MAX_FIX))
                        d.st = ST_FIX;
                    else
                        d.st = ST_SCAN;
                end
            end
            ST_FIX: begin
                buf_addr = AW'(cur_loc >> 3);
                if (cur_loc < LOC_W'(DATA_BITS)) begin
                    buf_we    = 1'b1;
                    buf_wdata = buf_rdata ^ (8'h01 << cur_loc[2:0]);
                end
                if (q.idx == AW'(q.cnt) - AW'(1)) begin
                    d.st    = ST_DONE;
                    d.fixed = q.cnt;
                end else begin
                    d.idx = q.idx + AW'(1);
                end
            end
            ST_SCAN: begin
                if (q.idx < AW'(DATA_BYTES))
                    d.dz = sat_add(q.dz, byte_zeros);
                else
                    d.ez = sat_add(q.ez, byte_zeros);
                if (q.idx == AW'(TOT_BYTES - 1)) begin
                    zero_total = (ZW+1)'(d.dz) + (ZW+1)'(d.ez);
                    d.idx      = '0;
                    if (zero_total <= (ZW+1)'(MAX_FIX)) begin
                        d.st    = ST_FILL;
                        d.fixed = CNT_W'(zero_total);
                    end else begin
                        d.st  = ST_DONE;
                        d.bad = 1'b1;
                    end
                end else begin
                    d.idx = q.idx + AW'(1);
                end
            end
            ST_FILL: begin
                buf_we    = 1'b1;
                buf_wdata = 8'hFF;
                if (q.idx == AW'(DATA_BYTES - 1))
                    d.st = ST_DONE;
                else
                    d.idx = q.idx + AW'(1);
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done          = (q.st == ST_DONE);
    assign corrected     = q.fixed;
    assign uncorrectable = q.bad;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_addr < AW'(DATA_BYTES))); // R4
    AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FIX && buf_we) |-> $countones(buf_wdata ^ buf_rdata) == 1); // R4
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !buf_we); // R1
    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> corrected == '0); // R8
    AST_FIX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> corrected <= CNT_W'(MAX_FIX)); // R5
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FIX && q.idx != AW'(q.cnt) - AW'(1)) |=> q.st == ST_FIX); // R9

endmodule

// File: tb/bfx_corrector_tb.sv
`timescale 1ns/1ps
module bfx_corrector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] w1 = '0, w2 = '0, w3 = '0, st = '0;
    logic [9:0]  buf_addr;
    logic [7:0]  buf_rdata, buf_wdata;
    logic        buf_we, done, uncorrectable;
    logic [3:0]  corrected;

    logic [7:0]  ram     [0:524];
    logic [7:0]  ref_mem [0:524];
    logic [12:0] fld     [0:7];
    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    bfx_corrector u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ecc_w1(w1), .ecc_w2(w2), .ecc_w3(w3), .status(st),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .done(done), .corrected(corrected),
        .uncorrectable(uncorrectable)
    );

    assign buf_rdata = (buf_addr < 10'd525) ? ram[buf_addr] : 8'h00;
    always @(posedge clk) if (buf_we && buf_addr < 10'd525) ram[buf_addr] <= buf_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic fill_pattern(input int seed);
        for (int b = 0; b < 525; b++) ram[b] = 8'((b * 37 + seed) ^ (b >> 2));
    endtask

    task automatic fill_ones();
        for (int b = 0; b < 525; b++) ram[b] = 8'hFF;
    endtask

    function automatic int zeros_of(input logic [7:0] v);
        int z = 0;
        for (int i = 0; i < 8; i++) if (!v[i]) z++;
        return z;
    endfunction

    task automatic run_case(input int cnt, input bit poke, input string tag);
        logic [103:0] pk;
        int lat, loc, zd, ze, tot, exp_fix, mism;
        bit exp_bad;
        for (int k = 0; k < 8; k++) pk[k*13 +: 13] = fld[k];
        for (int b = 0; b < 525; b++) ref_mem[b] = ram[b];
        exp_fix = 0; exp_bad = 0;
        if (cnt == 0) begin
            lat = 1;
        end else if (cnt <= 8) begin
            for (int i = 0; i < cnt; i++) begin
                loc = int'(fld[i]) ^ 3;
                if (loc < 4096) ref_mem[loc >> 3][loc & 7] = ~ref_mem[loc >> 3][loc & 7];
            end
            exp_fix = cnt;
            lat = cnt + 1;
        end else begin
            zd = 0; ze = 0;
            for (int b = 0; b < 512; b++) zd += zeros_of(ram[b]);
            for (int b = 512; b < 525; b++) ze += zeros_of(ram[b]);
            tot = zd + ze;
            if (tot <= 8) begin
                for (int b = 0; b < 512; b++) ref_mem[b] = 8'hFF;
                exp_fix = tot;
                lat = 1038;
            end else begin
                exp_bad = 1;
                lat = 526;
            end
        end
        @(negedge clk);
        w1 = pk[31:0]; w2 = pk[63:32]; w3 = pk[95:64];
        st = {8'hA5, pk[103:96], 2'b11, 4'(cnt), 10'h2B3};
        start = 1'b1;
        for (int c = 1; c <= lat + 1; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 1) start = 1'b0;
            if (poke && c == 2) begin
                w1 = ~w1; w2 = ~w2; st = {st[31:14], 4'd0, st[9:0]}; start = 1'b1;
            end
            if (poke && c == 3) start = 1'b0;
            chk(done == (c == lat), {tag, " done timing"}, int'(done), int'(c == lat));
            if (c == lat) begin
                chk(corrected == 4'(exp_fix), {tag, " corrected"}, int'(corrected), exp_fix);
                chk(uncorrectable == exp_bad, {tag, " uncorrectable"}, int'(uncorrectable), int'(exp_bad));
            end
            if (c == lat + 1) begin
                chk(corrected == 4'(exp_fix), {tag, " R10 held"}, int'(corrected), exp_fix);
            end
        end
        mism = 0;
        for (int b = 0; b < 525; b++) if (ram[b] !== ref_mem[b]) mism++;
        chk(mism == 0, {tag, " buffer"}, mism, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        fill_pattern(11);
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R10 reset done", int'(done), 0);
        chk(buf_we == 1'b0, "R1 reset write", int'(buf_we), 0);
        chk(corrected == 4'd0, "R10 reset corrected", int'(corrected), 0);
        chk(uncorrectable == 1'b0, "R8 reset flag", int'(uncorrectable), 0);
        rst_n = 1'b1;

        // R1: count zero, garbage locations
        for (int k = 0; k < 8; k++) fld[k] = 13'(k * 301 + 5);
        run_case(0, 0, "R1 count0");

        // R3 R4: single location 0 -> adjusted 3
        fld[0] = 13'h0000;
        for (int k = 1; k < 8; k++) fld[k] = 13'h0155;
        fill_pattern(3);
        run_case(1, 0, "R3 single");

        // R2 R4: all eight, spanning fields, 4095 and 4096 limits
        fld[0] = 13'd4092; fld[1] = 13'd4099; fld[2] = 13'h0005; fld[3] = 13'h1ABC;
        fld[4] = 13'h0A5A; fld[5] = 13'h0F00; fld[6] = 13'h0001; fld[7] = 13'h07FF;
        fill_pattern(29);
        run_case(8, 0, "R2 R4 eight");

        // R5: only first three, rest would hit byte 0
        fld[0] = 13'h0010; fld[1] = 13'h0123; fld[2] = 13'h0456;
        for (int k = 3; k < 8; k++) fld[k] = 13'h0000;
        fill_pattern(47);
        run_case(3, 0, "R5 partial");

        // R5: duplicate cancels
        fld[0] = 13'h0100; fld[1] = 13'h0100;
        run_case(2, 0, "R5 duplicate");

        // R9: start during fix ignored
        for (int k = 0; k < 8; k++) fld[k] = 13'(k * 517 + 40);
        fill_pattern(61);
        run_case(5, 1, "R9 busy start");

        // R6 R7: erased page with exactly 8 zero bits
        fill_ones();
        ram[5] = 8'hF0; ram[300] = 8'hFE; ram[512] = 8'h7F; ram[524] = 8'hFC;
        run_case(9, 0, "R7 erased8");

        // R6 R8: nine zero bits
        fill_ones();
        ram[5] = 8'hF0; ram[300] = 8'hFE; ram[512] = 8'h7F; ram[524] = 8'hFC; ram[100] = 8'hEF;
        run_case(12, 0, "R8 nine");

        // R6 R7: clean erased page
        fill_ones();
        run_case(15, 0, "R6 clean");

        // R8: ordinary data with high count
        fill_pattern(83);
        run_case(10, 0, "R8 data");

        summary();
        $finish;
    end
endmodule